// File: doc/BRIEF.md
# Serial Segment Driver Register

This block takes display data one bit at a time and holds it for a bank of segment drivers. A serial bit stream is loaded into a shift register whose length is a parameter (60 by default). The last stage is presented on a serial output, so several blocks can be chained into one longer register. A rising edge on a strobe input copies the whole shift register into a holding latch of the same width. The latch feeds the driver outputs through a two-input override stage. One input blanks the display and the other lights every segment for a lamp test.

Everything runs on a single fabric clock. A `shift_en` qualifier marks the cycles that count as shift-clock edges. The strobe is sampled on the same clock, and its rising edge is found by comparing it with its value one cycle earlier. If a shift edge arrives while the strobe is high, both the shift register and the latch are cleared. The driver outputs are registered and follow the latch or the override one clock later.

Top module: `seg_drv_reg`

## Requirements
- R1: On a clock edge with `shift_en` high and `strobe` low, every stage moves up by one. Stage 1 (bit 0 of the internal vector) takes `ser_in`, and stage k+1 takes the old stage k.
- R2: Data is positive logic. A 1 loaded at stage k lights `drv[k-1]` once that data has been latched and passed to the outputs.
- R3: `ser_out` equals the last stage. A bit shifted in appears on `ser_out` after N shift edges, and the N+1st shift edge moves it into stage 1 of a chained block.
- R4: The latch copies the shift register only on the first clock edge where `strobe` is sampled high after being low, and only when `shift_en` is low on that edge. At every other edge, apart from the clearing case in R5, it holds its value. This includes edges where the strobe stays high.
- R5: A clock edge where `shift_en` and `strobe` are both high zeroes the shift register and the latch. This takes priority over shifting and capture.
- R6: When `blank_n` is low, every driver output is 0 one clock later, whatever the latch holds.
- R7: When `blank_n` is high and `test_all` is high, every driver output is 1 one clock later, whatever the latch holds.
- R8: Blanking has priority over the lamp test: `blank_n` low with `test_all` high gives all zeros.
- R9: The overrides do not alter the latch. When both are released, the outputs show the data latched before the overrides were applied.
- R10: Synchronous active-high `rst` zeroes the shift register, the latch, `ser_out` and all driver outputs.
- R11: With `blank_n` high and `test_all` low, `drv` equals the latch contents with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Marks a shift-clock edge |
| ser_in | input | 1 | Serial display data |
| strobe | input | 1 | Latch strobe; its rising edge captures the shift register, and held high it clears on a shift edge |
| blank_n | input | 1 | Low blanks all outputs |
| test_all | input | 1 | High lights all outputs, unless blanked |
| ser_out | output | 1 | Last shift stage, for chaining |
| drv | output | NCH | Registered driver outputs, bit k-1 for stage k |

## Verification
Two blocks are chained, and the bench drives three kinds of patterns: alternating bits, a single marker bit at the first and last positions, and a 120-bit stream across the whole chain. These show whether the stage order is reversed and whether the chained block receives its bits with the right offset. Strobes are given as one-cycle pulses, as long holds without shifting and as holds with shifting, which separates capture, hold and clear. The override inputs are applied in every combination over a non-trivial latch value, and the data is read back afterwards, so the priority of blanking and the untouched latch can both be observed.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
  typedef enum logic [1:0] {
    OUT_PASS  = 2'd0,
    OUT_BLANK = 2'd1,
    OUT_LIT   = 2'd2
  } out_mode_e;

  function automatic out_mode_e pick_mode(input logic blank_n, input logic test_all);
    if (!blank_n)      return OUT_BLANK;
    else if (test_all) return OUT_LIT;
    else               return OUT_PASS;
  endfunction
endpackage

// File: rtl/seg_shift.sv
module seg_shift #(
  parameter int NCH = 60
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           wipe,
  input  logic           ser_in,
  output logic [NCH-1:0] stages
);
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      stages <= '0;
    end else if (shift_en) begin
      stages <= {stages[NCH-2:0], ser_in};
    end
  end
endmodule

// File: rtl/seg_hold.sv
module seg_hold #(
  parameter int NCH = 60
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strobe,
  input  logic           shift_en,
  input  logic [NCH-1:0] par_in,
  output logic           wipe,
  output logic [NCH-1:0] held
);
  logic strobe_d;
  logic grab;

  assign wipe = shift_en & strobe;
  assign grab = strobe & ~strobe_d & ~shift_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_d <= 1'b0;
    end else begin
      strobe_d <= strobe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      held <= '0;
    end else if (grab) begin
      held <= par_in;
    end
  end
endmodule

// File: rtl/seg_gate.sv
module seg_gate
  import seg_drv_pkg::*;
#(
  parameter int NCH = 60
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           blank_n,
  input  logic           test_all,
  input  logic [NCH-1:0] held,
  output logic [NCH-1:0] drv
);
  out_mode_e mode;
  assign mode = pick_mode(blank_n, test_all);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        drv[g] <= 1'b0;
      end else begin
        case (mode)
          OUT_BLANK: drv[g] <= 1'b0;
          OUT_LIT:   drv[g] <= 1'b1;
          default:   drv[g] <= held[g];
        endcase
      end
    end
  end
endmodule

// File: rtl/seg_drv_reg.sv
module seg_drv_reg #(
  parameter int NCH = 60
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           ser_in,
  input  logic           strobe,
  input  logic           blank_n,
  input  logic           test_all,
  output logic           ser_out,
  output logic [NCH-1:0] drv
);
  logic [NCH-1:0] stages;
  logic [NCH-1:0] held;
  logic           wipe;

  seg_shift #(.NCH(NCH)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .wipe(wipe),
    .ser_in(ser_in), .stages(stages)
  );

  seg_hold #(.NCH(NCH)) u_hold (
    .clk(clk), .rst(rst), .strobe(strobe), .shift_en(shift_en),
    .par_in(stages), .wipe(wipe), .held(held)
  );

  seg_gate #(.NCH(NCH)) u_gate (
    .clk(clk), .rst(rst), .blank_n(blank_n), .test_all(test_all),
    .held(held), .drv(drv)
  );

  assign ser_out = stages[NCH-1];
endmodule

// File: rtl/seg_drv_chk.sv
module seg_drv_chk #(
  parameter int NCH = 60
) (
  input logic           clk,
  input logic           rst,
  input logic           shift_en,
  input logic           ser_in,
  input logic           strobe,
  input logic           blank_n,
  input logic           test_all,
  input logic           ser_out,
  input logic [NCH-1:0] drv,
  input logic [NCH-1:0] stages,
  input logic [NCH-1:0] held
);
  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !strobe) |=> (stages[0] == $past(ser_in)));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobe) |=> $stable(held));
  p_wipe_r5: assert property (@(posedge clk) disable iff (rst)
    (shift_en && strobe) |=> (held == '0 && !ser_out));
  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    (!blank_n) |=> (drv == '0));
  p_lit_r7: assert property (@(posedge clk) disable iff (rst)
    (blank_n && test_all) |=> (drv == '1));
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (drv == '0 && held == '0 && !ser_out));
  p_pass_r11: assert property (@(posedge clk) disable iff (rst)
    (blank_n && !test_all) |=> (drv == $past(held)));
endmodule

bind seg_drv_reg seg_drv_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
  .strobe(strobe), .blank_n(blank_n), .test_all(test_all),
  .ser_out(ser_out), .drv(drv), .stages(stages), .held(held)
);

// File: tb/tb_seg_drv_reg.sv
module tb_seg_drv_reg;
  localparam int NCH = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0, ser_in = 1'b0, strobe = 1'b0;
  logic blank_n = 1'b1;   // pull-up-like default: not blanked
  logic test_all = 1'b0;  // pull-down default: lamp test off
  logic so_a, so_b;
  logic [NCH-1:0] drv_a, drv_b;

  always #4 clk = ~clk;

  seg_drv_reg #(.NCH(NCH)) dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .strobe(strobe),
    .blank_n(blank_n), .test_all(test_all), .ser_out(so_a), .drv(drv_a)
  );
  seg_drv_reg #(.NCH(NCH)) dut_b (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(so_a), .strobe(strobe),
    .blank_n(blank_n), .test_all(test_all), .ser_out(so_b), .drv(drv_b)
  );

  int nchk = 0, nfail = 0;
  logic [2*NCH-1:0] chain = '0;
  logic [2*NCH-1:0] lat = '0;

  typedef struct { logic [2*NCH-1:0] v; string req; } exp_t;
  exp_t sb[$];

  task automatic push_exp(input logic [2*NCH-1:0] v, input string req);
    exp_t e; e.v = v; e.req = req; sb.push_back(e);
  endtask

  task automatic monitor_pop();
    exp_t e;
    e = sb.pop_front();
    nchk++;
    if ({drv_b, drv_a} !== e.v) begin
      nfail++;
      $display("FAIL %s drv actual=%h expected=%h", e.req, {drv_b, drv_a}, e.v);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); shift_en = 1'b0; strobe = 1'b0;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); shift_en = 1'b1; ser_in = b; strobe = 1'b0;
    chain = {chain[2*NCH-2:0], b};
  endtask

  task automatic pulse();
    @(negedge clk); shift_en = 1'b0; strobe = 1'b1;
    lat = chain;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic settle();
    idle(); idle();
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    push_exp('0, "R10");
    monitor_pop();
    chk1(so_b, 1'b0, "R10 ser_out");
    rst = 1'b0;
    idle();

    // R1 R2 R11: alternating pattern into the first block
    for (int i = 0; i < NCH; i++) shift_bit(i[0]);
    pulse(); settle();
    push_exp(lat, "R1 R2 R11 alternating");
    monitor_pop();

    // R3: single marker reaches last stage after N shifts
    for (int i = 0; i < NCH; i++) shift_bit(i == 0);
    idle();
    chk1(so_a, 1'b1, "R3 marker on ser_out after N shifts");
    shift_bit(1'b0); idle();
    chk1(so_a, 1'b0, "R3 marker left last stage");
    pulse(); settle();
    push_exp(lat, "R3 marker in chained block stage 1");
    monitor_pop();

    // R3: 120-bit stream through the chain
    for (int i = 0; i < 2*NCH; i++) shift_bit((i % 3) == 0 || i == 7);
    pulse(); settle();
    push_exp(lat, "R3 cascade stream");
    monitor_pop();

    // R4: shifting without a strobe leaves outputs unchanged
    for (int i = 0; i < 10; i++) shift_bit(1'b1);
    settle();
    push_exp(lat, "R4 no strobe no update");
    monitor_pop();

    // R4: strobe held high without shifting captures once, then holds
    @(negedge clk); strobe = 1'b1; lat = chain;
    repeat (5) @(negedge clk);
    strobe = 1'b0;
    settle();
    push_exp(lat, "R4 held strobe");
    monitor_pop();

    // R7: lamp test
    @(negedge clk); test_all = 1'b1; settle();
    push_exp('1, "R7 lamp test");
    monitor_pop();
    // R8: blanking wins over lamp test
    @(negedge clk); blank_n = 1'b0; settle();
    push_exp('0, "R8 blank priority");
    monitor_pop();
    // R6: blanking alone
    @(negedge clk); test_all = 1'b0; settle();
    push_exp('0, "R6 blank");
    monitor_pop();
    // R9: latch intact after overrides
    @(negedge clk); blank_n = 1'b1; settle();
    push_exp(lat, "R9 latch kept");
    monitor_pop();

    // R5: strobe high during a shift edge clears everything
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); shift_en = 1'b1; ser_in = 1'b1;
    @(negedge clk); shift_en = 1'b0; strobe = 1'b0;
    chain = '0; lat = '0;
    settle();
    push_exp('0, "R5 clear latch");
    monitor_pop();
    chk1(so_a, 1'b0, "R5 clear shift A");
    chk1(so_b, 1'b0, "R5 clear shift B");
    pulse(); settle();
    push_exp('0, "R5 shift register emptied");
    monitor_pop();

    // R1: last-position marker
    for (int i = 0; i < NCH; i++) shift_bit(i == NCH-1);
    pulse(); settle();
    push_exp(lat, "R1 marker in stage 1");
    monitor_pop();

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1; settle();
    push_exp('0, "R10 reset mid-run");
    monitor_pop();
    chk1(so_a, 1'b0, "R10 ser_out after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule